// File: doc/BRIEF.md
# Sectioned Clock Register Window

This block stands between a two-wire serial slave, which has already turned the bus into start, stop, word-address and data-byte events, and the 64-byte clock and control register space of a real-time clock. It decides which section an address falls in. It moves the byte pointer forward without leaving that section. It holds alarm and control bytes, and it shows the running time through a copy taken when an operation starts. Write data for a whole operation is kept in a buffer and released only when the bus stop arrives.

The space has five sections: alarm 0 at 00h–07h, alarm 1 at 08h–0Fh, control at 10h–13h, time at 30h–37h and status at 3Fh. Every other address is undefined. The status byte carries two protection bits. Writes to alarm, control and time registers are released only while both bits are set, and the bits are raised by two successive status writes.

Top module: `rtc_reg_window`

## Requirements
- R1: After reset, rdValid and commitStb are 0, both protection bits are clear, and every alarm and control byte reads 00h.
- R2: A read returns the stored byte for alarm addresses (00h–0Fh) and control addresses (10h–13h). Time address 30h+i returns byte i of the time copy, which is liveTime[8i+7:8i]. Status (3Fh) returns {flagsIn[3], flagsIn[2], flagsIn[1], 0, 0, RWEL, WEL, flagsIn[0]}. Any undefined address reads 00h, and a write to it buffers nothing and produces no commit.
- R3: After each accepted byte the pointer advances by one. Past the last byte of its section it wraps to that section's first byte, so it goes from 07h to 00h, 0Fh to 08h, 13h to 10h and 37h to 30h. At 3Fh it stays at 3Fh.
- R4: When an operation's first data byte is at status, any further data byte in that operation ends it. That byte and all later read or write bytes are ignored (rdValid stays 0) until the next start. A status byte already buffered still commits at stop.
- R5: When a stop commits a status write of byte d, WEL takes d[1] and RWEL takes d[2] AND d[1] AND the WEL value held before. Alarm, control and time writes commit only if WEL and RWEL are both set at the stop. Otherwise they are dropped without a commit.
- R6: Writes are buffered. In the cycle after a stop that releases them, commitStb pulses once with commitSect (1 alarm 0, 2 alarm 1, 3 control, 4 time, 5 status), commitMask (bit i = byte at section offset i, offset 7 for status) and commitData (byte i in bits 8i+7:8i).
- R7: Every start copies liveTime into the time copy. Changes on liveTime after that start do not change the bytes read.
- R8: The pointer keeps its value across stop and start, so a read without a new word address continues at the address after the last byte accessed.
- R9: A start arriving while write bytes are buffered discards them. A following stop then commits nothing.
- R10: rdData and rdValid are registered and are valid in the cycle after rdStrobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busStart | input | 1 | Start or repeated start seen (one-cycle pulse) |
| busStop | input | 1 | Stop seen (one-cycle pulse) |
| addrLoad | input | 1 | Word address byte received |
| addrIn | input | 6 | Word address to load into the pointer |
| wrStrobe | input | 1 | Write data byte received |
| wrData | input | 8 | Write data byte |
| rdStrobe | input | 1 | Master requests the next read byte |
| liveTime | input | 64 | Running time registers, byte i for address 30h+i |
| flagsIn | input | 4 | Live status flags {battery, alarm 1, alarm 0, clock fail} |
| rdData | output | 8 | Read byte |
| rdValid | output | 1 | rdData carries a fresh byte |
| commitStb | output | 1 | One-cycle commit pulse |
| commitSect | output | 3 | Section being committed |
| commitMask | output | 8 | Bytes written in this commit |
| commitData | output | 64 | Committed byte values |

## Verification
The assertions assume that the serial front end reports at most one event per cycle: a start, a stop, an address load, a write byte or a read byte. They also assume that read and write bytes come only after a start. The bench drives every event as a single-cycle pulse with an idle cycle after it, so events never coincide. Each operation begins with a start, which keeps the properties on pointer wrap, protection and snapshot stability inside those assumptions.

// File: rtl/rtc_reg_window_pkg.sv
package rtc_reg_window_pkg;
  localparam int ADDR_W     = 6;
  localparam int BYTE_W     = 8;
  localparam int TIME_BYTES = 8;
  localparam int ALM_BYTES  = 16;
  localparam int CTL_BYTES  = 4;
  localparam int NV_BYTES   = ALM_BYTES + CTL_BYTES;
  localparam int NV_IDX_W   = $clog2(NV_BYTES + 12);

  typedef enum logic [2:0] {
    SEC_NONE = 3'd0,
    SEC_AL0  = 3'd1,
    SEC_AL1  = 3'd2,
    SEC_CTL  = 3'd3,
    SEC_TIME = 3'd4,
    SEC_STAT = 3'd5
  } sect_e;

  typedef struct packed {
    logic snap;
    logic clrBuf;
    logic bufWr;
    logic rdLoad;
    logic commit;
  } strobe_t;

  function automatic sect_e sectOf(input logic [ADDR_W-1:0] a);
    if (a[5:4] == 2'b00)        return a[3] ? SEC_AL1 : SEC_AL0;
    else if (a[5:2] == 4'b0100) return SEC_CTL;
    else if (a[5:3] == 3'b110)  return SEC_TIME;
    else if (a == 6'h3F)        return SEC_STAT;
    else                        return SEC_NONE;
  endfunction

  function automatic logic [ADDR_W-1:0] nextAddr(input logic [ADDR_W-1:0] a);
    case (sectOf(a))
      SEC_AL0, SEC_AL1, SEC_TIME: return {a[5:3], a[2:0] + 3'd1};
      SEC_CTL:                    return {a[5:2], a[1:0] + 2'd1};
      SEC_STAT:                   return a;
      default:                    return a + 6'd1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_reg_window_ctrl.sv
module rtc_reg_window_ctrl
  import rtc_reg_window_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busStart,
  input  logic              busStop,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              wrStrobe,
  input  logic [1:0]        statBits,
  input  logic              rdStrobe,
  output strobe_t           st,
  output logic [ADDR_W-1:0] ptr,
  output sect_e             bufSect,
  output logic              wel,
  output logic              rwel
);
  logic  opDead, firstDone, statusOp, bufAny;
  logic [1:0] statData;
  sect_e curSect;
  logic  accessOk;

  always_comb begin
    curSect   = sectOf(ptr);
    accessOk  = !opDead && !(firstDone && statusOp);
    st.snap   = busStart;
    st.clrBuf = busStart | busStop | addrLoad;
    st.bufWr  = wrStrobe && accessOk && (curSect != SEC_NONE);
    st.rdLoad = rdStrobe && accessOk;
    st.commit = busStop && bufAny && ((bufSect == SEC_STAT) || (wel && rwel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      opDead    <= 1'b0;
      firstDone <= 1'b0;
      statusOp  <= 1'b0;
      bufAny    <= 1'b0;
      bufSect   <= SEC_NONE;
      statData  <= '0;
      wel       <= 1'b0;
      rwel      <= 1'b0;
    end else if (busStart || busStop) begin
      opDead    <= 1'b0;
      firstDone <= 1'b0;
      statusOp  <= 1'b0;
      bufAny    <= 1'b0;
      if (busStop && bufAny && bufSect == SEC_STAT) begin
        wel  <= statData[0];
        rwel <= statData[1] & statData[0] & wel;
      end
    end else if (addrLoad) begin
      ptr       <= addrIn;
      bufAny    <= 1'b0;
      firstDone <= 1'b0;
      statusOp  <= 1'b0;
    end else if ((wrStrobe || rdStrobe) && !opDead) begin
      if (firstDone && statusOp) begin
        opDead <= 1'b1;
      end else begin
        firstDone <= 1'b1;
        statusOp  <= (curSect == SEC_STAT);
        ptr       <= nextAddr(ptr);
        if (wrStrobe && curSect != SEC_NONE) begin
          bufAny  <= 1'b1;
          bufSect <= curSect;
          if (curSect == SEC_STAT) statData <= statBits;
        end
      end
    end
  end

  // R5: the second protection level never stands without the first
  p_rwel_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);

  // R3: an access inside the time section keeps the pointer inside it
  p_time_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (curSect == SEC_TIME && (wrStrobe || rdStrobe)) |=> (ptr[5:3] == 3'b110));

  // R4: a terminated operation stays terminated until start or stop
  p_dead_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (opDead && !busStart && !busStop) |=> opDead);
endmodule

// File: rtl/rtc_reg_window_dp.sv
module rtc_reg_window_dp
  import rtc_reg_window_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  strobe_t                      st,
  input  logic [ADDR_W-1:0]            ptr,
  input  sect_e                        bufSect,
  input  logic                         wel,
  input  logic                         rwel,
  input  logic [BYTE_W-1:0]            wrData,
  input  logic [TIME_BYTES*BYTE_W-1:0] liveTime,
  input  logic [3:0]                   flagsIn,
  output logic [BYTE_W-1:0]            rdData,
  output logic                         rdValid,
  output logic                         commitStb,
  output logic [2:0]                   commitSect,
  output logic [TIME_BYTES-1:0]        commitMask,
  output logic [TIME_BYTES*BYTE_W-1:0] commitData
);
  logic [TIME_BYTES*BYTE_W-1:0] snapTime;
  logic [BYTE_W-1:0]            nvReg   [NV_BYTES];
  logic [BYTE_W-1:0]            bufData [TIME_BYTES];
  logic [TIME_BYTES-1:0]        bufMask;
  logic [NV_IDX_W-1:0]          nvIdx;
  logic [BYTE_W-1:0]            rdMux;
  sect_e                        rdSect;

  always_comb begin
    rdSect = sectOf(ptr);
    nvIdx  = (rdSect == SEC_CTL) ? NV_IDX_W'(ALM_BYTES + int'(ptr[1:0]))
                                 : NV_IDX_W'(ptr[3:0]);
    case (rdSect)
      SEC_AL0, SEC_AL1, SEC_CTL: rdMux = nvReg[nvIdx];
      SEC_TIME: rdMux = snapTime[{ptr[2:0], 3'b000} +: BYTE_W];
      SEC_STAT: rdMux = {flagsIn[3:1], 2'b00, rwel, wel, flagsIn[0]};
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snapTime   <= '0;
      bufMask    <= '0;
      rdData     <= '0;
      rdValid    <= 1'b0;
      commitStb  <= 1'b0;
      commitSect <= '0;
      commitMask <= '0;
      commitData <= '0;
      for (int i = 0; i < NV_BYTES; i++) nvReg[i] <= '0;
      for (int i = 0; i < TIME_BYTES; i++) bufData[i] <= '0;
    end else begin
      if (st.snap) snapTime <= liveTime;
      if (st.clrBuf) bufMask <= '0;
      else if (st.bufWr) begin
        bufData[ptr[2:0]] <= wrData;
        bufMask[ptr[2:0]] <= 1'b1;
      end
      rdValid <= st.rdLoad;
      if (st.rdLoad) rdData <= rdMux;
      commitStb <= st.commit;
      if (st.commit) begin
        commitSect <= bufSect;
        commitMask <= bufMask;
        for (int i = 0; i < TIME_BYTES; i++) begin
          commitData[i*BYTE_W +: BYTE_W] <= bufData[i];
          if (bufMask[i]) begin
            if (bufSect == SEC_AL0)      nvReg[i] <= bufData[i];
            else if (bufSect == SEC_AL1) nvReg[8+i] <= bufData[i];
          end
        end
        for (int i = 0; i < CTL_BYTES; i++)
          if (bufMask[i] && bufSect == SEC_CTL) nvReg[ALM_BYTES+i] <= bufData[i];
      end
    end
  end

  // R7: the time copy moves only on a start
  p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !st.snap |=> $stable(snapTime));

  // R5: no protected section is committed while locked
  p_locked_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commitStb && commitSect != 3'(SEC_STAT)) |-> (wel && rwel));

  // R2: undefined addresses read as zero
  p_undef_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && $past(sectOf(ptr) == SEC_NONE)) |-> (rdData == 8'h00));
endmodule

// File: rtl/rtc_reg_window.sv
module rtc_reg_window
  import rtc_reg_window_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busStart,
  input  logic        busStop,
  input  logic        addrLoad,
  input  logic [5:0]  addrIn,
  input  logic        wrStrobe,
  input  logic [7:0]  wrData,
  input  logic        rdStrobe,
  input  logic [63:0] liveTime,
  input  logic [3:0]  flagsIn,
  output logic [7:0]  rdData,
  output logic        rdValid,
  output logic        commitStb,
  output logic [2:0]  commitSect,
  output logic [7:0]  commitMask,
  output logic [63:0] commitData
);
  strobe_t           st;
  logic [ADDR_W-1:0] ptr;
  sect_e             bufSect;
  logic              wel, rwel;

  rtc_reg_window_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .busStart(busStart), .busStop(busStop),
    .addrLoad(addrLoad), .addrIn(addrIn), .wrStrobe(wrStrobe),
    .statBits(wrData[2:1]), .rdStrobe(rdStrobe), .st(st), .ptr(ptr),
    .bufSect(bufSect), .wel(wel), .rwel(rwel)
  );

  rtc_reg_window_dp u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .ptr(ptr), .bufSect(bufSect),
    .wel(wel), .rwel(rwel), .wrData(wrData), .liveTime(liveTime),
    .flagsIn(flagsIn), .rdData(rdData), .rdValid(rdValid),
    .commitStb(commitStb), .commitSect(commitSect),
    .commitMask(commitMask), .commitData(commitData)
  );

  // input assumption: one bus event per cycle
  p_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busStart, busStop, addrLoad, wrStrobe, rdStrobe}));

  // R6: a commit pulse follows a stop
  p_commit_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commitStb |-> $past(busStop));
endmodule

// File: tb/rtc_reg_window_bench.sv
module rtc_reg_window_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] OP_START = 3'd0, OP_STOP = 3'd1, OP_ADDR = 3'd2,
                         OP_WR = 3'd3, OP_RD = 3'd4, OP_RDDEAD = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] arg;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 59;
  localparam vec_t VECS [NV] = '{
    // R5: locked write to alarm 0 is dropped
    '{OP_START,8'h00,8'h00,4'd5}, '{OP_ADDR,8'h00,8'h00,4'd5}, '{OP_WR,8'h11,8'h00,4'd5},
    '{OP_STOP,8'h00,8'h00,4'd5}, '{OP_START,8'h00,8'h00,4'd5}, '{OP_ADDR,8'h00,8'h00,4'd5},
    '{OP_START,8'h00,8'h00,4'd5}, '{OP_RD,8'h00,8'h00,4'd5}, '{OP_STOP,8'h00,8'h00,4'd5},
    // R5: two-step unlock, status reads 06h
    '{OP_START,8'h00,8'h00,4'd5}, '{OP_ADDR,8'h3F,8'h00,4'd5}, '{OP_WR,8'h02,8'h00,4'd5},
    '{OP_STOP,8'h00,8'h01,4'd5}, '{OP_START,8'h00,8'h00,4'd5}, '{OP_ADDR,8'h3F,8'h00,4'd5},
    '{OP_WR,8'h06,8'h00,4'd5}, '{OP_STOP,8'h00,8'h01,4'd5}, '{OP_START,8'h00,8'h00,4'd5},
    '{OP_ADDR,8'h3F,8'h00,4'd5}, '{OP_START,8'h00,8'h00,4'd5}, '{OP_RD,8'h00,8'h06,4'd5},
    '{OP_STOP,8'h00,8'h00,4'd5},
    // R3: alarm 0 page write wraps 07h -> 00h; R8: current-address read
    '{OP_START,8'h00,8'h00,4'd3}, '{OP_ADDR,8'h06,8'h00,4'd3}, '{OP_WR,8'hA1,8'h00,4'd3},
    '{OP_WR,8'hA2,8'h00,4'd3}, '{OP_WR,8'hA3,8'h00,4'd3}, '{OP_STOP,8'h00,8'h01,4'd6},
    '{OP_START,8'h00,8'h00,4'd3}, '{OP_ADDR,8'h06,8'h00,4'd3}, '{OP_START,8'h00,8'h00,4'd3},
    '{OP_RD,8'h00,8'hA1,4'd3}, '{OP_RD,8'h00,8'hA2,4'd3}, '{OP_STOP,8'h00,8'h00,4'd3},
    '{OP_START,8'h00,8'h00,4'd8}, '{OP_RD,8'h00,8'hA3,4'd8}, '{OP_STOP,8'h00,8'h00,4'd8},
    // R3: control wraps 13h -> 10h
    '{OP_START,8'h00,8'h00,4'd3}, '{OP_ADDR,8'h13,8'h00,4'd3}, '{OP_WR,8'hC3,8'h00,4'd3},
    '{OP_WR,8'hC0,8'h00,4'd3}, '{OP_STOP,8'h00,8'h01,4'd6}, '{OP_START,8'h00,8'h00,4'd3},
    '{OP_ADDR,8'h12,8'h00,4'd3}, '{OP_START,8'h00,8'h00,4'd3}, '{OP_RD,8'h00,8'h00,4'd3},
    '{OP_RD,8'h00,8'hC3,4'd3}, '{OP_RD,8'h00,8'hC0,4'd3}, '{OP_STOP,8'h00,8'h00,4'd3},
    // R9: repeated start discards buffered bytes
    '{OP_START,8'h00,8'h00,4'd9}, '{OP_ADDR,8'h08,8'h00,4'd9}, '{OP_WR,8'h77,8'h00,4'd9},
    '{OP_START,8'h00,8'h00,4'd9}, '{OP_STOP,8'h00,8'h00,4'd9}, '{OP_START,8'h00,8'h00,4'd9},
    '{OP_ADDR,8'h08,8'h00,4'd9}, '{OP_START,8'h00,8'h00,4'd9}, '{OP_RD,8'h00,8'h00,4'd9},
    '{OP_STOP,8'h00,8'h00,4'd9}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic busStart = 0, busStop = 0, addrLoad = 0, wrStrobe = 0, rdStrobe = 0;
  logic [5:0]  addrIn = '0;
  logic [7:0]  wrData = '0;
  logic [63:0] liveTime = '0;
  logic [3:0]  flagsIn = '0;
  logic [7:0]  rdData;
  logic        rdValid, commitStb;
  logic [2:0]  commitSect;
  logic [7:0]  commitMask;
  logic [63:0] commitData;
  int nChecks = 0, nFails = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_reg_window u_rtc_reg_window (
    .clk(clk), .rst_n(rst_n), .busStart(busStart), .busStop(busStop),
    .addrLoad(addrLoad), .addrIn(addrIn), .wrStrobe(wrStrobe), .wrData(wrData),
    .rdStrobe(rdStrobe), .liveTime(liveTime), .flagsIn(flagsIn),
    .rdData(rdData), .rdValid(rdValid), .commitStb(commitStb),
    .commitSect(commitSect), .commitMask(commitMask), .commitData(commitData)
  );

  task automatic check(input bit ok, input int req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic runOp(input logic [2:0] op, input logic [7:0] arg,
                       input logic [7:0] exp, input int req);
    @(negedge clk);
    case (op)
      OP_START: busStart = 1;
      OP_STOP:  busStop = 1;
      OP_ADDR:  begin addrLoad = 1; addrIn = arg[5:0]; end
      OP_WR:    begin wrStrobe = 1; wrData = arg; end
      default:  rdStrobe = 1;
    endcase
    @(negedge clk);
    {busStart, busStop, addrLoad, wrStrobe, rdStrobe} = '0;
    case (op)
      OP_RD: begin
        check(rdValid == 1'b1, req, 64'(rdValid), 64'd1, "read valid");
        check(rdData == exp, req, 64'(rdData), 64'(exp), "read data");
      end
      OP_RDDEAD: check(rdValid == 1'b0, req, 64'(rdValid), 64'd0, "ignored read");
      OP_STOP: check(commitStb == exp[0], req, 64'(commitStb), 64'(exp[0]), "commit pulse");
      default: ;
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, 0, 64'd0, 64'd1, "watchdog expired");
    report();
  end

  initial begin
    for (int i = 0; i < 8; i++) liveTime[i*8 +: 8] = 8'(8'h40 + i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rdValid == 1'b0, 1, 64'(rdValid), 64'd0, "rdValid after reset");
    check(commitStb == 1'b0, 1, 64'(commitStb), 64'd0, "commitStb after reset");
    runOp(OP_START, 0, 0, 1); runOp(OP_ADDR, 8'h3F, 0, 1); runOp(OP_START, 0, 0, 1);
    runOp(OP_RD, 0, 8'h00, 1); runOp(OP_STOP, 0, 0, 1);
    runOp(OP_START, 0, 0, 1); runOp(OP_ADDR, 8'h11, 0, 1); runOp(OP_START, 0, 0, 1);
    runOp(OP_RD, 0, 8'h00, 1); runOp(OP_STOP, 0, 0, 1);

    for (int v = 0; v < NV; v++)
      runOp(VECS[v].op, VECS[v].arg, VECS[v].exp, int'(VECS[v].req));

    // R7: copy taken at start; R2: time bytes; R3: 37h wraps to 30h
    runOp(OP_START, 0, 0, 7); runOp(OP_ADDR, 8'h37, 0, 7); runOp(OP_START, 0, 0, 7);
    runOp(OP_RD, 0, 8'h47, 2); runOp(OP_RD, 0, 8'h40, 3);
    for (int i = 0; i < 8; i++) liveTime[i*8 +: 8] = 8'(8'h50 + i);
    runOp(OP_RD, 0, 8'h41, 7); runOp(OP_STOP, 0, 0, 7);
    // R8: continue at 32h with a fresh copy
    runOp(OP_START, 0, 0, 8); runOp(OP_RD, 0, 8'h52, 8); runOp(OP_STOP, 0, 0, 8);

    // R2: undefined address ignored on write, zero on read
    runOp(OP_START, 0, 0, 2); runOp(OP_ADDR, 8'h20, 0, 2); runOp(OP_WR, 8'h55, 0, 2);
    runOp(OP_STOP, 0, 8'h00, 2);
    runOp(OP_START, 0, 0, 2); runOp(OP_ADDR, 8'h20, 0, 2); runOp(OP_START, 0, 0, 2);
    runOp(OP_RD, 0, 8'h00, 2); runOp(OP_STOP, 0, 0, 2);

    // R4: status allows one byte per operation
    runOp(OP_START, 0, 0, 4); runOp(OP_ADDR, 8'h3F, 0, 4); runOp(OP_START, 0, 0, 4);
    runOp(OP_RD, 0, 8'h06, 4); runOp(OP_RDDEAD, 0, 0, 4); runOp(OP_WR, 8'h00, 0, 4);
    runOp(OP_STOP, 0, 8'h00, 4);
    runOp(OP_START, 0, 0, 4); runOp(OP_ADDR, 8'h3F, 0, 4); runOp(OP_WR, 8'h06, 0, 4);
    runOp(OP_WR, 8'h00, 0, 4); runOp(OP_STOP, 0, 8'h01, 4);
    runOp(OP_START, 0, 0, 4); runOp(OP_ADDR, 8'h3F, 0, 4); runOp(OP_START, 0, 0, 4);
    runOp(OP_RD, 0, 8'h06, 4); runOp(OP_STOP, 0, 0, 4);

    // R6: time write 36h,37h,30h committed with fields
    runOp(OP_START, 0, 0, 6); runOp(OP_ADDR, 8'h36, 0, 6); runOp(OP_WR, 8'hAB, 0, 6);
    runOp(OP_WR, 8'hCD, 0, 6); runOp(OP_WR, 8'hEF, 0, 6);
    check(commitStb == 1'b0, 6, 64'(commitStb), 64'd0, "no commit before stop");
    runOp(OP_STOP, 0, 8'h01, 6);
    check(commitSect == 3'd4, 6, 64'(commitSect), 64'd4, "commit section");
    check(commitMask == 8'hC1, 6, 64'(commitMask), 64'hC1, "commit mask");
    check({commitData[63:48], commitData[7:0]} == 24'hCDABEF, 6,
          64'({commitData[63:48], commitData[7:0]}), 64'hCDABEF, "commit data");
    @(negedge clk);
    check(commitStb == 1'b0, 6, 64'(commitStb), 64'd0, "single pulse");

    // R5: relock, then a protected write is dropped
    runOp(OP_START, 0, 0, 5); runOp(OP_ADDR, 8'h3F, 0, 5); runOp(OP_WR, 8'h00, 0, 5);
    runOp(OP_STOP, 0, 8'h01, 5);
    runOp(OP_START, 0, 0, 5); runOp(OP_ADDR, 8'h00, 0, 5); runOp(OP_WR, 8'h99, 0, 5);
    runOp(OP_STOP, 0, 8'h00, 5);
    runOp(OP_START, 0, 0, 5); runOp(OP_ADDR, 8'h00, 0, 5); runOp(OP_START, 0, 0, 5);
    runOp(OP_RD, 0, 8'hA3, 5); runOp(OP_STOP, 0, 0, 5);
    // R5: 06h without prior WEL sets WEL only; R2: status flag layout
    runOp(OP_START, 0, 0, 5); runOp(OP_ADDR, 8'h3F, 0, 5); runOp(OP_WR, 8'h06, 0, 5);
    runOp(OP_STOP, 0, 8'h01, 5);
    flagsIn = 4'b1011;
    runOp(OP_START, 0, 0, 2); runOp(OP_ADDR, 8'h3F, 0, 2); runOp(OP_START, 0, 0, 2);
    runOp(OP_RD, 0, 8'hA3, 2); runOp(OP_STOP, 0, 0, 2);
    // R10: no read strobe, no valid
    @(negedge clk);
    check(rdValid == 1'b0, 10, 64'(rdValid), 64'd0, "valid only after strobe");
    report();
  end
endmodule